// File: doc/BRIEF.md
# Privileged Control Register File

This block keeps the thirty-two control registers of a small processor core, selected by a 5-bit index. The core's control-read and control-write instructions reach it through one index, a write data bus and two strobes. The two return-from-handler instructions reach it through two request lines. Each register has its own writable mask and its own read-only mask, both set by parameter. Every write merges new data with the old contents through these masks. A register whose writable mask is zero cannot be changed.

The pending-interrupt register holds no state. A read of it returns the hardware interrupt lines ANDed with the interrupt-enable register. All accesses are allowed in supervisor mode only. In user mode an access raises a privilege fault and changes nothing. A supervisor write to the status register or to the enable register raises a pipeline-flush request, so that the core sees interrupts that were just enabled. A return request copies the saved status into status and hands the core a redirect target, taken from the exception-return register or the breakpoint-return register.

Top module: `priv_ctrl_regs`

## Requirements
- R1: A read of any index other than 0, 1, 2, 3, 4, 5, 7, 8, 9, 10, 12, 13, 14 or 15 returns zero, even after a write to that index.
- R2: A read of index 4 returns `irq_i` ANDed with the contents of index 3 (interrupt enable).
- R3: A write to a register whose writable mask is zero leaves it unchanged. With the default masks this covers index 5, which keeps 0x000000A5.
- R4: Any other write stores (data AND writable mask) OR (old value AND read-only mask). Bits in neither mask read as zero. With the default masks, index 10 has writable mask 0x0000FFFF and read-only mask 0xFFFF0000, index 13 has writable mask 0x1, and index 1 has writable mask 0x3.
- R5: When `user_mode_i` is high, a read, a write, or either return request raises `priv_fault_o` in the same cycle. The read returns zero, no register changes, and neither `flush_o` nor `redirect_o` rises.
- R6: `flush_o` is high in the cycle of a supervisor write to index 0 or index 3, and low for a write to any other index.
- R7: A supervisor exception return (`eret_i`) raises `redirect_o` with `redirect_pc_o` = `ea_i` in the same cycle, and from the next edge index 0 holds the value of index 1.
- R8: A supervisor breakpoint return (`bret_i`) raises `redirect_o` with `redirect_pc_o` = `ba_i` in the same cycle, and from the next edge index 0 holds the value of index 2.
- R9: After reset, index 0 reads zero and every other register reads its parameter reset value. With the default parameters, index 5 reads 0x000000A5 and index 10 reads 0x12340000.
- R10: A write takes effect on the rising clock edge. Reads are combinational, so a written value can be read back in the next cycle.
- R11: At most one of `rd_en_i`, `wr_en_i`, `eret_i` and `bret_i` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | 5 | Register index |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| eret_i | input | 1 | Exception-return request |
| bret_i | input | 1 | Breakpoint-return request |
| user_mode_i | input | 1 | Core is in user mode |
| irq_i | input | 32 | Hardware interrupt lines |
| ea_i | input | 32 | Exception-return address register |
| ba_i | input | 32 | Breakpoint-return address register |
| rdata_o | output | 32 | Read data |
| priv_fault_o | output | 1 | Privileged-instruction fault |
| flush_o | output | 1 | Pipeline-flush request |
| redirect_o | output | 1 | Return redirect valid |
| redirect_pc_o | output | 32 | Return redirect target |

## Verification
Read data, the fault, the flush request and the redirect are combinational, so they are due in the same cycle as the strobe. Register contents change only at the next rising edge. The bench drives each strobe at a falling edge and checks the combinational outputs 1 ns later, while the strobe is still held. It checks a register's new value only with a read issued at the falling edge after the write or return edge. It never samples at a rising edge, so no check depends on whether a write has landed yet.

// File: rtl/priv_ctrl_pkg.sv
package priv_ctrl_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NREG = 32;
  localparam int unsigned IDXW = $clog2(NREG);

  localparam logic [IDXW-1:0] IX_STATUS  = 5'd0;
  localparam logic [IDXW-1:0] IX_ESTATUS = 5'd1;
  localparam logic [IDXW-1:0] IX_BSTATUS = 5'd2;
  localparam logic [IDXW-1:0] IX_IENABLE = 5'd3;
  localparam logic [IDXW-1:0] IX_IPEND   = 5'd4;

  function automatic bit idx_defined(int unsigned i);
    case (i)
      0, 1, 2, 3, 4, 5, 7, 8, 9, 10, 12, 13, 14, 15: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [NREG*XLEN-1:0] dflt_wr_masks();
    logic [NREG*XLEN-1:0] v = '0;
    v[0*XLEN +: XLEN]  = 32'h0000_0003;
    v[1*XLEN +: XLEN]  = 32'h0000_0003;
    v[2*XLEN +: XLEN]  = 32'h0000_0003;
    v[3*XLEN +: XLEN]  = 32'hFFFF_FFFF;
    v[8*XLEN +: XLEN]  = 32'hFFFF_FFFF;
    v[9*XLEN +: XLEN]  = 32'hFFFF_FFFF;
    v[10*XLEN +: XLEN] = 32'h0000_FFFF;
    v[13*XLEN +: XLEN] = 32'h0000_0001;
    v[14*XLEN +: XLEN] = 32'hFFFF_FFFF;
    v[15*XLEN +: XLEN] = 32'hFFFF_FFFF;
    return v;
  endfunction

  function automatic logic [NREG*XLEN-1:0] dflt_ro_masks();
    logic [NREG*XLEN-1:0] v = '0;
    v[5*XLEN +: XLEN]  = 32'hFFFF_FFFF;
    v[7*XLEN +: XLEN]  = 32'hFFFF_FFFF;
    v[10*XLEN +: XLEN] = 32'hFFFF_0000;
    v[12*XLEN +: XLEN] = 32'hFFFF_FFFF;
    return v;
  endfunction

  function automatic logic [NREG*XLEN-1:0] dflt_rst_vals();
    logic [NREG*XLEN-1:0] v = '0;
    v[5*XLEN +: XLEN]  = 32'h0000_00A5;
    v[10*XLEN +: XLEN] = 32'h1234_0000;
    return v;
  endfunction
endpackage

// File: rtl/ctrl_reg_slot.sv
module ctrl_reg_slot #(
  parameter int unsigned W   = 32,
  parameter logic [W-1:0] WR  = '0,
  parameter logic [W-1:0] RO  = '0,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_en_i,
  input  logic [W-1:0] load_d_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] KEEP = WR | RO;

  logic [W-1:0] q_r;

  generate
    if (WR != '0) begin : g_wr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        q_r <= RST & KEEP;
        else if (load_en_i) q_r <= load_d_i & KEEP;
        else if (wr_en_i)   q_r <= (wdata_i & WR) | (q_r & RO);
      end

      // R4
      merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !load_en_i) |=> q_o == (($past(wdata_i) & WR) | ($past(q_o) & RO)));
    end else begin : g_ro
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        q_r <= RST & KEEP;
        else if (load_en_i) q_r <= load_d_i & KEEP;
      end

      // R3
      ro_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !load_en_i) |=> $stable(q_o));
    end
  endgenerate

  assign q_o = q_r;
endmodule

// File: rtl/ctrl_read_mux.sv
module ctrl_read_mux
  import priv_ctrl_pkg::*;
(
  input  logic [IDXW-1:0]      idx_i,
  input  logic                 rd_ok_i,
  input  logic [NREG*XLEN-1:0] regs_i,
  input  logic [XLEN-1:0]      irq_i,
  output logic [XLEN-1:0]      rdata_o
);
  logic [NREG-1:0] defined;

  for (genvar i = 0; i < NREG; i++) begin : g_def
    assign defined[i] = idx_defined(i);
  end

  always_comb begin
    rdata_o = '0;
    if (rd_ok_i && defined[idx_i]) begin
      if (idx_i == IX_IPEND)
        rdata_o = irq_i & regs_i[IX_IENABLE*XLEN +: XLEN];
      else
        rdata_o = regs_i[idx_i*XLEN +: XLEN];
    end
  end
endmodule

// File: rtl/priv_ctrl_regs.sv
module priv_ctrl_regs
  import priv_ctrl_pkg::*;
#(
  parameter logic [NREG*XLEN-1:0] WR_MASKS = dflt_wr_masks(),
  parameter logic [NREG*XLEN-1:0] RO_MASKS = dflt_ro_masks(),
  parameter logic [NREG*XLEN-1:0] RST_VALS = dflt_rst_vals()
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [4:0]      idx_i,
  input  logic [31:0]     wdata_i,
  input  logic            rd_en_i,
  input  logic            wr_en_i,
  input  logic            eret_i,
  input  logic            bret_i,
  input  logic            user_mode_i,
  input  logic [31:0]     irq_i,
  input  logic [31:0]     ea_i,
  input  logic [31:0]     ba_i,
  output logic [31:0]     rdata_o,
  output logic            priv_fault_o,
  output logic            flush_o,
  output logic            redirect_o,
  output logic [31:0]     redirect_pc_o
);
  logic                 any_req;
  logic                 wr_ok;
  logic                 ret_ok;
  logic [XLEN-1:0]      ret_status;
  logic [NREG*XLEN-1:0] regs;

  assign any_req      = rd_en_i | wr_en_i | eret_i | bret_i;
  assign priv_fault_o = user_mode_i & any_req;
  assign wr_ok        = wr_en_i & ~user_mode_i;
  assign ret_ok       = (eret_i | bret_i) & ~user_mode_i;
  assign ret_status   = eret_i ? regs[IX_ESTATUS*XLEN +: XLEN]
                               : regs[IX_BSTATUS*XLEN +: XLEN];
  assign flush_o      = wr_ok & ((idx_i == IX_STATUS) | (idx_i == IX_IENABLE));
  assign redirect_o   = ret_ok;
  assign redirect_pc_o = ret_ok ? (eret_i ? ea_i : ba_i) : '0;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam logic [XLEN-1:0] WR_I  = WR_MASKS[i*XLEN +: XLEN];
    localparam logic [XLEN-1:0] RO_I  = RO_MASKS[i*XLEN +: XLEN];
    localparam logic [XLEN-1:0] RST_I = (i == 0) ? '0 : RST_VALS[i*XLEN +: XLEN];
    localparam bit              LIVE  = idx_defined(i) && (i != 4);

    if (LIVE) begin : g_live
      logic slot_wr;
      logic slot_ld;
      assign slot_wr = wr_ok && (idx_i == i[IDXW-1:0]);
      assign slot_ld = (i == 0) ? ret_ok : 1'b0;
      ctrl_reg_slot #(.W(XLEN), .WR(WR_I), .RO(RO_I), .RST(RST_I)) u_slot (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (slot_wr),
        .wdata_i  (wdata_i),
        .load_en_i(slot_ld),
        .load_d_i (ret_status),
        .q_o      (regs[i*XLEN +: XLEN])
      );
    end else begin : g_void
      assign regs[i*XLEN +: XLEN] = '0;
    end
  end

  ctrl_read_mux u_rmux (
    .idx_i  (idx_i),
    .rd_ok_i(rd_en_i & ~user_mode_i),
    .regs_i (regs),
    .irq_i  (irq_i),
    .rdata_o(rdata_o)
  );

  // R11
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_en_i, wr_en_i, eret_i, bret_i}));

  // R5
  user_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_mode_i && (wr_en_i || eret_i || bret_i)) |=> $stable(regs));

  // R7
  eret_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !user_mode_i) |=>
      regs[IX_STATUS*XLEN +: XLEN] ==
      ($past(regs[IX_ESTATUS*XLEN +: XLEN]) &
       (WR_MASKS[IX_STATUS*XLEN +: XLEN] | RO_MASKS[IX_STATUS*XLEN +: XLEN])));

  // R8
  bret_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bret_i && !user_mode_i) |=>
      regs[IX_STATUS*XLEN +: XLEN] ==
      ($past(regs[IX_BSTATUS*XLEN +: XLEN]) &
       (WR_MASKS[IX_STATUS*XLEN +: XLEN] | RO_MASKS[IX_STATUS*XLEN +: XLEN])));

  // R2
  ipend_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !user_mode_i && idx_i == IX_IPEND) |->
      rdata_o == (irq_i & regs[IX_IENABLE*XLEN +: XLEN]));
endmodule

// File: tb/priv_ctrl_regs_test.sv
module priv_ctrl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0, eret = 1'b0, bret = 1'b0, user = 1'b0;
  logic [31:0] irq = '0, ea = '0, ba = '0;
  logic [31:0] rdata, redirect_pc;
  logic        fault, flush, redirect;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  priv_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx), .wdata_i(wdata),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .eret_i(eret), .bret_i(bret),
    .user_mode_i(user), .irq_i(irq), .ea_i(ea), .ba_i(ba),
    .rdata_o(rdata), .priv_fault_o(fault), .flush_o(flush),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  idx;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 5'd5,  32'h0,         32'h0000_00A5, 8'd9},  // R9
    '{1'b0, 5'd10, 32'h0,         32'h1234_0000, 8'd9},  // R9
    '{1'b0, 5'd0,  32'h0,         32'h0,         8'd9},  // R9
    '{1'b1, 5'd10, 32'hFFFF_FFFF, 32'h1234_FFFF, 8'd4},  // R4
    '{1'b1, 5'd13, 32'hFFFF_FFFF, 32'h0000_0001, 8'd4},  // R4
    '{1'b1, 5'd5,  32'h0,         32'h0000_00A5, 8'd3},  // R3
    '{1'b1, 5'd6,  32'hDEAD_BEEF, 32'h0,         8'd1},  // R1
    '{1'b0, 5'd20, 32'h0,         32'h0,         8'd1},  // R1
    '{1'b1, 5'd8,  32'hCAFE_F00D, 32'hCAFE_F00D, 8'd10}, // R10
    '{1'b1, 5'd1,  32'hFFFF_FFFF, 32'h0000_0003, 8'd4}   // R4
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // drive write at negedge, check combinational outputs, release after edge
  task automatic do_write(input logic [4:0] i, input logic [31:0] d, input logic u,
                          input logic exp_flush, input string req);
    @(negedge clk);
    idx = i; wdata = d; wr_en = 1'b1; user = u;
    #1;
    check(flush == exp_flush, req, {31'b0, flush}, {31'b0, exp_flush});
    check(fault == u, req, {31'b0, fault}, {31'b0, u});
    @(negedge clk);
    wr_en = 1'b0; user = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] i, input logic u, input logic [31:0] exp,
                         input string req);
    idx = i; rd_en = 1'b1; user = u;
    #1;
    check(rdata == exp, req, rdata, exp);
    check(fault == u, req, {31'b0, fault}, {31'b0, u});
    #1;
    rd_en = 1'b0; user = 1'b0;
  endtask

  task automatic do_return(input bit is_e, input logic u, input logic [31:0] tgt,
                           input string req);
    @(negedge clk);
    ea = 32'h0000_1000; ba = 32'h0000_2000;
    eret = is_e; bret = !is_e; user = u;
    #1;
    check(redirect == !u, req, {31'b0, redirect}, {31'b0, !u});
    if (!u) check(redirect_pc == tgt, req, redirect_pc, tgt);
    check(fault == u, req, {31'b0, fault}, {31'b0, u});
    @(negedge clk);
    eret = 1'b0; bret = 1'b0; user = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[k].req, k);
      if (VECS[k].wr) do_write(VECS[k].idx, VECS[k].data, 1'b0, 1'b0, tag);
      do_read(VECS[k].idx, 1'b0, VECS[k].exp, tag);
    end

    // R6 + R2: enable write flushes, pending is masked view
    do_write(5'd3, 32'h0000_00F0, 1'b0, 1'b1, "R6 ienable");
    irq = 32'h0000_0FFF;
    do_read(5'd4, 1'b0, 32'h0000_00F0, "R2 ipending");
    irq = 32'h0000_0030;
    do_read(5'd4, 1'b0, 32'h0000_0030, "R2 ipending");
    do_write(5'd4, 32'hFFFF_FFFF, 1'b0, 1'b0, "R3 ipending write");
    do_read(5'd4, 1'b0, 32'h0000_0030, "R3 ipending write");
    do_write(5'd0, 32'h0, 1'b0, 1'b1, "R6 status");
    do_write(5'd9, 32'h5, 1'b0, 1'b0, "R6 other index");

    // R7: estatus holds 3
    do_return(1'b1, 1'b0, 32'h0000_1000, "R7 eret");
    do_read(5'd0, 1'b0, 32'h0000_0003, "R7 status");

    // R8
    do_write(5'd2, 32'h0000_0002, 1'b0, 1'b0, "R8 bstatus");
    do_return(1'b0, 1'b0, 32'h0000_2000, "R8 bret");
    do_read(5'd0, 1'b0, 32'h0000_0002, "R8 status");

    // R5: user mode accesses fault and do nothing
    do_write(5'd8, 32'h1111_1111, 1'b1, 1'b0, "R5 user write");
    do_read(5'd8, 1'b0, 32'hCAFE_F00D, "R5 user write");
    do_write(5'd3, 32'h0, 1'b1, 1'b0, "R5 user enable write");
    do_read(5'd3, 1'b0, 32'h0000_00F0, "R5 user enable write");
    do_read(5'd8, 1'b1, 32'h0, "R5 user read");
    do_return(1'b1, 1'b1, 32'h0, "R5 user eret");
    do_read(5'd0, 1'b0, 32'h0000_0002, "R5 user eret");

    // R9: reset again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_read(5'd0, 1'b0, 32'h0, "R9 status after reset");
    do_read(5'd10, 1'b0, 32'h1234_0000, "R9 index 10 after reset");
    do_read(5'd8, 1'b0, 32'h0, "R9 index 8 after reset");

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule